// File: doc/BRIEF.md
# Non-Scan Testable Controller State Machine

This block is a small ten-state controller whose state register can be driven during test without any scan chain. A four-bit binary state register normally follows an untouched next-state function of the present state and a two-bit step input. A test-mode select swaps that function for an autonomous generator. The generator walks the register through three codes that normal operation can never reach, then returns it to state zero. This lets a tester put each unreachable code into the register at full clock rate.

A hold control freezes the register so that several input values can be applied against one state. The value about to enter the register is driven out on an observation bus every cycle. A one-bit parity of that bus serves when pins are short. Parity catches any corruption of an odd number of bits and misses one of an even number.

Top module: `nst_ctrl_top`

## Requirements
- R1: With rst high at a rising clock edge, the register takes code 0 after that edge, whatever the values of hold, test_mode, step and the present state.
- R2: With rst, hold and test_mode all low, the register takes (present code + step) mod 10 at the edge, where step is the unsigned value of the two-bit step input. This holds for every code the register can contain, including codes 10, 11 and 12.
- R3: With rst and hold low and test_mode high, the register takes the generator value at the edge, and step has no effect. The generator maps 0 to 10, 10 to 11, 11 to 12, 12 to 0, and every other code to 0.
- R4: Starting from code 0 with test_mode held high, successive edges give the repeating sequence 10, 11, 12, 0.
- R5: With rst low and hold high, the register keeps its present code at the edge, whatever test_mode and step are.
- R6: The obs output always equals the code that the register will hold after the next rising edge, with rst, hold and test_mode priorities applied in that order.
- R7: The out bit 0 is high exactly when the register holds code 9. The out bit 1 is high exactly when the register holds a code of 5 or more. Both come from the registered state.
- R8: The obs_par output equals the XOR of the four obs bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset to code 0 |
| test_mode | input | 1 | 1 selects the unreachable-code generator as next state |
| hold | input | 1 | 1 freezes the state register |
| step | input | 2 | Functional input: state advance amount |
| out | output | 2 | Moore outputs: bit 0 is state 9, bit 1 is state of 5 or more |
| obs | output | 4 | Value presented at the state register input |
| obs_par | output | 1 | XOR parity of obs |

## Verification
A wrong state code appears on obs in the same cycle in which it is computed, one edge before the register holds it. Any faulty select, hold or generator path therefore shows up as a miscompare on obs at once. A corrupted register value shows up on obs in the next cycle, because both the hold path and the next-state paths are built from the register. It also shows up on the out bits whenever it crosses the 5 or 9 boundaries. A single-bit error also flips obs_par in that same cycle.

// File: rtl/nst_ctrl_pkg.sv
package nst_ctrl_pkg;
   localparam int STATE_W   = 4;
   localparam int STEP_W    = 2;
   localparam int NUM_VALID = 10;
   localparam int INV_BASE  = 10;
   localparam int INV_COUNT = 3;
   localparam int OUT_W     = 2;
   typedef logic [STATE_W-1:0] state_t;
endpackage

// File: rtl/nst_next_fn.sv
module nst_next_fn
   import nst_ctrl_pkg::*;
#(
   parameter int W      = STATE_W,
   parameter int SW     = STEP_W,
   parameter int NVALID = NUM_VALID
) (
   input  logic [W-1:0]  cur,
   input  logic [SW-1:0] step,
   output logic [W-1:0]  nxt,
   output logic          at_last,
   output logic          upper_half
);
   localparam int SUM_W = W + 2;

   initial begin
      if (NVALID < 2 || NVALID > (1 << W))
         $error("nst_next_fn: NVALID out of range");
   end

   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] red;

   always_comb begin
      sum = SUM_W'(cur) + SUM_W'(step);
      red = sum;
      for (int k = 0; k < 3; k++) begin
         if (red >= SUM_W'(NVALID))
            red = red - SUM_W'(NVALID);
      end
      nxt = red[W-1:0];
   end

   assign at_last    = (cur == W'(NVALID - 1));
   assign upper_half = (cur >= W'(NVALID / 2));

   // R2
   always_comb begin
      if (!$isunknown(nxt))
         nxt_in_range_chk: assert (nxt < W'(NVALID));
   end
endmodule

// File: rtl/nst_bad_gen.sv
module nst_bad_gen
   import nst_ctrl_pkg::*;
#(
   parameter int W      = STATE_W,
   parameter int BASE   = INV_BASE,
   parameter int COUNT  = INV_COUNT,
   parameter int NVALID = NUM_VALID
) (
   input  logic [W-1:0] cur,
   output logic [W-1:0] gen
);
   localparam int LAST = BASE + COUNT - 1;

   initial begin
      if (BASE < NVALID || LAST >= (1 << W) || COUNT < 1)
         $error("nst_bad_gen: generated codes must be unreachable and fit");
   end

   logic [COUNT:0] hit;
   logic [W-1:0]   succ [COUNT+1];

   assign hit[0]  = (cur == '0);
   assign succ[0] = W'(BASE);

   for (genvar g = 0; g < COUNT; g++) begin : g_walk
      assign hit[g+1]  = (cur == W'(BASE + g));
      assign succ[g+1] = (g == COUNT - 1) ? '0 : W'(BASE + g + 1);
   end

   always_comb begin
      gen = '0;
      for (int k = 0; k <= COUNT; k++) begin
         if (hit[k]) gen = succ[k];
      end
   end

   // R3
   always_comb begin
      if (!$isunknown(gen))
         gen_code_chk: assert (gen == '0 || (gen >= W'(BASE) && gen <= W'(LAST)));
   end
endmodule

// File: rtl/nst_state_reg.sv
module nst_state_reg
   import nst_ctrl_pkg::*;
#(
   parameter int W = STATE_W
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         hold,
   input  logic         test_mode,
   input  logic [W-1:0] fn_next,
   input  logic [W-1:0] gen_next,
   output logic [W-1:0] d_val,
   output logic [W-1:0] q
);
   logic [W-1:0] sel;

   assign sel   = test_mode ? gen_next : fn_next;
   assign d_val = rst ? '0 : (hold ? q : sel);

   always_ff @(posedge clk) begin
      q <= d_val;
   end

   // R1
   property p_reset;
      @(posedge clk) rst |=> (q == '0);
   endproperty
   reset_to_zero_chk: assert property (p_reset);

   // R5
   property p_hold;
      @(posedge clk) disable iff (rst) hold |=> (q == $past(q));
   endproperty
   hold_frozen_chk: assert property (p_hold);

   // R6
   property p_obs;
      @(posedge clk) disable iff (rst) !rst |=> (q == $past(d_val));
   endproperty
   obs_matches_load_chk: assert property (p_obs);

   // R3
   property p_gen;
      @(posedge clk) disable iff (rst) (!hold && test_mode) |=> (q == $past(gen_next));
   endproperty
   gen_loaded_chk: assert property (p_gen);
endmodule

// File: rtl/nst_ctrl_top.sv
module nst_ctrl_top
   import nst_ctrl_pkg::*;
#(
   parameter int W      = STATE_W,
   parameter int SW     = STEP_W,
   parameter int NVALID = NUM_VALID,
   parameter int BASE   = INV_BASE,
   parameter int COUNT  = INV_COUNT
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          test_mode,
   input  logic          hold,
   input  logic [SW-1:0] step,
   output logic [1:0]    out,
   output logic [W-1:0]  obs,
   output logic          obs_par
);
   logic [W-1:0] q;
   logic [W-1:0] fn_next;
   logic [W-1:0] gen_next;
   logic [W-1:0] d_val;
   logic         at_last;
   logic         upper_half;

   nst_next_fn #(.W(W), .SW(SW), .NVALID(NVALID)) u_fn (
      .cur(q), .step(step), .nxt(fn_next),
      .at_last(at_last), .upper_half(upper_half)
   );

   nst_bad_gen #(.W(W), .BASE(BASE), .COUNT(COUNT), .NVALID(NVALID)) u_gen (
      .cur(q), .gen(gen_next)
   );

   nst_state_reg #(.W(W)) u_reg (
      .clk(clk), .rst(rst), .hold(hold), .test_mode(test_mode),
      .fn_next(fn_next), .gen_next(gen_next), .d_val(d_val), .q(q)
   );

   assign out = {upper_half, at_last};
   assign obs = d_val;

   logic [W:0] par_chain;
   assign par_chain[0] = 1'b0;
   for (genvar b = 0; b < W; b++) begin : g_par
      assign par_chain[b+1] = par_chain[b] ^ d_val[b];
   end
   assign obs_par = par_chain[W];

   // R8
   always_comb begin
      if (!$isunknown(obs))
         par_match_chk: assert (obs_par == ($countones(obs) % 2 == 1));
   end
endmodule

// File: tb/nst_ctrl_top_tb.sv
module nst_ctrl_top_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst;
   logic       test_mode;
   logic       hold;
   logic [1:0] step;
   logic [1:0] out;
   logic [3:0] obs;
   logic       obs_par;

   int checks = 0;
   int fails  = 0;
   int exp_s  = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #(CLK_PERIOD/2) clk = ~clk;

   nst_ctrl_top u_dut (
      .clk(clk), .rst(rst), .test_mode(test_mode), .hold(hold),
      .step(step), .out(out), .obs(obs), .obs_par(obs_par)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int gen_of(input int s);
      if (s == 0) return 10;
      if (s == 10) return 11;
      if (s == 11) return 12;
      return 0;
   endfunction

   task automatic cyc(input logic r, input logic h, input logic t, input logic [1:0] p);
      int exp_d;
      string tag;
      @(negedge clk);
      rst = r; hold = h; test_mode = t; step = p;
      #1;
      if (r) begin exp_d = 0; tag = "R1"; end
      else if (h) begin exp_d = exp_s; tag = "R5"; end
      else if (t) begin exp_d = gen_of(exp_s); tag = "R3"; end
      else begin exp_d = (exp_s + int'(p)) % 10; tag = "R2"; end
      chk({tag, "/R6 obs"}, int'(obs), exp_d);
      chk("R8 parity", int'(obs_par), int'(^exp_d[3:0]));
      chk("R7 out", int'(out), ((exp_s >= 5) ? 2 : 0) + ((exp_s == 9) ? 1 : 0));
      @(posedge clk);
      exp_s = exp_d;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      rst = 1'b1; hold = 1'b0; test_mode = 1'b0; step = 2'd0;
      @(posedge clk);
      exp_s = 0;
      cyc(1'b1, 1'b0, 1'b0, 2'd3);
      // R1 reset state, seen through hold on obs
      cyc(1'b0, 1'b1, 1'b0, 2'd0);
      chk("R1 reset code", int'(obs), 0);

      // R4 generator walk twice, step toggled to show R3 independence
      for (int i = 0; i < 8; i++) begin
         cyc(1'b0, 1'b0, 1'b1, 2'(i));
         chk("R4 walk", exp_s, (i % 4 == 3) ? 0 : 10 + (i % 4));
      end

      // R2 on every code 0..12 with every step
      for (int s = 0; s <= 12; s++) begin
         for (int p = 0; p < 4; p++) begin
            cyc(1'b1, 1'b0, 1'b0, 2'd0);
            if (s >= 10) begin
               cyc(1'b0, 1'b0, 1'b1, 2'd0);
               for (int k = 10; k < s; k++) cyc(1'b0, 1'b0, 1'b1, 2'd0);
            end else begin
               for (int k = 0; k < s; k++) cyc(1'b0, 1'b0, 1'b0, 2'd1);
            end
            cyc(1'b0, 1'b1, 1'b1, 2'(p));
            cyc(1'b0, 1'b0, 1'b0, 2'(p));
         end
      end

      // R1 priority over hold and test mode
      cyc(1'b0, 1'b0, 1'b0, 2'd3);
      cyc(1'b1, 1'b1, 1'b1, 2'd2);
      cyc(1'b0, 1'b1, 1'b0, 2'd0);

      // Mixed sweep
      for (int i = 0; i < 3000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cyc(lfsr[3:0] == 4'd0, lfsr[5:4] == 2'd0, lfsr[7:6] == 2'd0, lfsr[9:8]);
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule